// File: doc/BRIEF.md
# Power Sequencing and Auto Power-Off Controller

This block brings an instrument's switched supply up and down in a safe order. A low pulse on the power-button input, while the instrument is off, raises the switched-rail enable at once. The peripheral reset line is held low until a programmable number of milliseconds has passed, so the peripherals can initialise while their supply settles. A second button pulse, a software power-off request or an inactivity timeout reverses the order. The peripheral reset is asserted first, and the rail is dropped a fixed number of milliseconds later.

The inactivity timer counts milliseconds while the instrument is on. Any key strobe restarts it. It only acts on battery power: while the adapter-detect input is high the timer is held clear. A control bit can also switch it off. All timing comes from a millisecond tick that is divided down from the system clock. A small two-word register port gives access to the disable bit, the power-off request and the release delay. All inputs are assumed to be synchronous to the clock.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, rail_en and periph_rst_n are both low, the disable bit reads 0 and the delay word (address 1) reads RELEASE_DEF_MS.
- R2: A falling edge on pwr_btn_n while off raises rail_en within 3 cycles, with periph_rst_n still low.
- R3: periph_rst_n rises between (D-1) and D millisecond ticks after rail_en rises, where D is the value in register address 1.
- R4: A falling edge on pwr_btn_n while fully on drives periph_rst_n low within 3 cycles while rail_en stays high.
- R5: rail_en falls between SHUT_MS-1 and SHUT_MS ticks after periph_rst_n was driven low by a power-off.
- R6: On battery (adapter_present low), with the disable bit clear, IDLE_MS ticks without a key strobe start the power-off sequence.
- R7: A key_strobe pulse restarts the inactivity count from zero.
- R8: While adapter_present is high, no inactivity power-off occurs, and the count restarts from zero once it goes low.
- R9: With control bit 0 (auto-off disable) set, no inactivity power-off occurs.
- R10: Writing 1 to control bit 1 (address 0) while on starts the same power-off sequence as the button, within 4 cycles.
- R11: Button pulses during power-up or power-down have no effect on the sequence under way.
- R12: periph_rst_n is never high while rail_en is low.
- R13: Register reads return data one cycle after the address is presented. Address 0 returns bit 0 = disable, bit 2 = rail_en, bit 3 = periph_rst_n and bit 4 = adapter_present. Address 1 returns the release delay in ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, asserted when the always-on supply appears |
| pwr_btn_n | input | 1 | Power button, active-low pulse |
| adapter_present | input | 1 | High when running from the external adapter |
| key_strobe | input | 1 | One-cycle pulse on any user key activity |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control/status, 1 release delay |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Registered read data |
| rail_en | output | 1 | Switched-rail enable |
| periph_rst_n | output | 1 | Active-low peripheral reset |

## Verification
If the sequencer state is wrong, it shows up as a rail or reset edge that has no cause, or as one in the wrong order. These are seen within a cycle of the faulty transition. A wrong timer count does not show up until later. It appears as a release or shutdown edge outside its tick window, which is visible a few milliseconds after power-up or an inactivity period after the last key or adapter event. Because the bench matches every output edge against an expected window, both early and missing edges are caught.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_RAMP  = 2'd1,
    PS_ON    = 2'd2,
    PS_DRAIN = 2'd3
  } pwr_state_t;

  localparam logic ADDR_CTRL  = 1'b0;
  localparam logic ADDR_DELAY = 1'b1;
endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
  parameter int TICK_DIV = 200000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer #(
  parameter int IDLE_MS = 360000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  input  logic clear,
  output logic expire
);
  localparam int CW = $clog2(IDLE_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_MS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active || clear) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (tick) begin
      if (cnt == LAST) begin
        cnt    <= '0;
        expire <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        expire <= 1'b0;
      end
    end else begin
      expire <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_rail_fsm.sv
module pwr_rail_fsm
  import pwr_seq_pkg::*;
#(
  parameter int SHUT_MS = 10,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          on_req,
  input  logic          off_req,
  input  logic [DW-1:0] rel_ms,
  output pwr_state_t    state,
  output logic          rail_en,
  output logic          periph_rst_n
);
  localparam logic [DW:0] SHUT_LIM = (DW+1)'(SHUT_MS);

  logic [DW-1:0] tmr;
  logic [DW:0]   tmr_nxt;

  assign tmr_nxt = {1'b0, tmr} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= PS_OFF;
      rail_en      <= 1'b0;
      periph_rst_n <= 1'b0;
      tmr          <= '0;
    end else begin
      case (state)
        PS_OFF: if (on_req) begin
          state   <= PS_RAMP;
          rail_en <= 1'b1;
          tmr     <= '0;
        end
        PS_RAMP: if (tick) begin
          if (tmr_nxt >= {1'b0, rel_ms}) begin
            state        <= PS_ON;
            periph_rst_n <= 1'b1;
          end else begin
            tmr <= tmr_nxt[DW-1:0];
          end
        end
        PS_ON: if (off_req) begin
          state        <= PS_DRAIN;
          periph_rst_n <= 1'b0;
          tmr          <= '0;
        end
        PS_DRAIN: if (tick) begin
          if (tmr_nxt >= SHUT_LIM) begin
            state   <= PS_OFF;
            rail_en <= 1'b0;
          end else begin
            tmr <= tmr_nxt[DW-1:0];
          end
        end
        default: state <= PS_OFF;
      endcase
    end
  end

  assert_rail_before_release_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_en) |-> !periph_rst_n);

  assert_release_on_live_rail_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(periph_rst_n) |-> (rail_en && $past(rail_en)));

  assert_drop_after_reset_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rail_en) |-> (!periph_rst_n && !$past(periph_rst_n)));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int TICK_DIV       = 200000,
  parameter int IDLE_MS        = 360000,
  parameter int SHUT_MS        = 10,
  parameter int RELEASE_DEF_MS = 50,
  parameter int RW             = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_btn_n,
  input  logic          adapter_present,
  input  logic          key_strobe,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          rail_en,
  output logic          periph_rst_n
);
  localparam logic [RW-1:0] REL_DEF = RW'(RELEASE_DEF_MS);

  logic       tick;
  logic       btn_q;
  logic       btn_evt;
  logic       auto_dis;
  logic       sw_off;
  logic [RW-1:0] rel_ms;
  logic       idle_exp;
  logic       idle_clr;
  pwr_state_t state;

  assign btn_evt  = btn_q && !pwr_btn_n;
  assign idle_clr = key_strobe || adapter_present || auto_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_q    <= 1'b1;
      auto_dis <= 1'b0;
      sw_off   <= 1'b0;
      rel_ms   <= REL_DEF;
    end else begin
      btn_q  <= pwr_btn_n;
      sw_off <= 1'b0;
      if (reg_wr) begin
        if (reg_addr == ADDR_CTRL) begin
          auto_dis <= reg_wdata[0];
          sw_off   <= reg_wdata[1];
        end else begin
          rel_ms <= reg_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_addr == ADDR_DELAY) begin
      reg_rdata <= rel_ms;
    end else begin
      reg_rdata <= '0;
      reg_rdata[0] <= auto_dis;
      reg_rdata[2] <= rail_en;
      reg_rdata[3] <= periph_rst_n;
      reg_rdata[4] <= adapter_present;
    end
  end

  pwr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  pwr_idle_timer #(.IDLE_MS(IDLE_MS)) u_idle (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .active(state == PS_ON),
    .clear (idle_clr),
    .expire(idle_exp)
  );

  pwr_rail_fsm #(.SHUT_MS(SHUT_MS), .DW(RW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .on_req      (btn_evt),
    .off_req     (btn_evt || sw_off || idle_exp),
    .rel_ms      (rel_ms),
    .state       (state),
    .rail_en     (rail_en),
    .periph_rst_n(periph_rst_n)
  );

  assert_reset_needs_rail_R12: assert property (@(posedge clk) disable iff (rst)
    periph_rst_n |-> rail_en);

  assert_no_auto_off_on_adapter_R8: assert property (@(posedge clk) disable iff (rst)
    $past(adapter_present) |-> !idle_exp);
endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
  localparam int T  = 4;
  localparam int I  = 30;
  localparam int S  = 3;
  localparam int D0 = 5;
  localparam int RW = 16;

  localparam int EV_RAIL_UP = 1;
  localparam int EV_RAIL_DN = 2;
  localparam int EV_RST_UP  = 3;
  localparam int EV_RST_DN  = 4;

  typedef struct {
    int    kind;
    int    lo;
    int    hi;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_btn_n = 1'b1;
  logic adapter_present = 1'b0;
  logic key_strobe = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_addr = 1'b0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic rail_en, periph_rst_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  exp_t q[$];
  logic p_rail = 1'b0, p_rstn = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_seq_ctrl #(
    .TICK_DIV(T), .IDLE_MS(I), .SHUT_MS(S), .RELEASE_DEF_MS(D0), .RW(RW)
  ) u_pwr_seq_ctrl (
    .clk(clk), .rst(rst), .pwr_btn_n(pwr_btn_n), .adapter_present(adapter_present),
    .key_strobe(key_strobe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rail_en(rail_en),
    .periph_rst_n(periph_rst_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input int lo, input int hi, input string req);
    exp_t e;
    e.kind = kind; e.lo = cyc + lo; e.hi = cyc + hi; e.req = req;
    q.push_back(e);
  endtask

  task automatic note_ev(input int kind);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R11 unexpected output edge", kind, 0);
    end else begin
      e = q.pop_front();
      check(e.kind == kind, e.req, kind, e.kind);
      check(cyc >= e.lo && cyc <= e.hi, e.req, cyc, e.lo);
    end
  endtask

  // monitor: every output edge must match the head of the queue
  always @(negedge clk) begin
    if (rst) begin
      p_rail = rail_en;
      p_rstn = periph_rst_n;
    end else begin
      if (rail_en !== p_rail) note_ev(rail_en ? EV_RAIL_UP : EV_RAIL_DN);
      if (periph_rst_n !== p_rstn) note_ev(periph_rst_n ? EV_RST_UP : EV_RST_DN);
      p_rail = rail_en;
      p_rstn = periph_rst_n;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press();
    pwr_btn_n = 1'b0;
    wait_cyc(2);
    pwr_btn_n = 1'b1;
  endtask

  task automatic reg_write(input logic a, input logic [RW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    wait_cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [RW-1:0] d);
    reg_addr = a;
    wait_cyc(1);
    d = reg_rdata;
  endtask

  task automatic power_on(input int d);
    expect_ev(EV_RAIL_UP, 0, 3, "R2 rail rise");
    expect_ev(EV_RST_UP, (d-1)*T, d*T+6, "R3 reset release");
    press();
    while (!periph_rst_n) wait_cyc(1);
  endtask

  initial begin
    logic [RW-1:0] rd;
    wait_cyc(4);
    check(rail_en == 1'b0, "R1 rail after reset", rail_en, 0);
    check(periph_rst_n == 1'b0, "R1 reset line after reset", periph_rst_n, 0);
    rst = 1'b0;
    wait_cyc(1);
    reg_read(1'b1, rd);
    check(rd == D0, "R1 default delay", rd, D0);
    reg_read(1'b0, rd);
    check(rd[0] == 1'b0, "R1 disable default", rd[0], 0);

    // adapter power: on, no auto-off
    adapter_present = 1'b1;
    power_on(D0);
    reg_read(1'b0, rd);
    check(rd[4:2] == 3'b111, "R13 status bits", rd[4:2], 7);
    wait_cyc(2*I*T);
    check(rail_en == 1'b1, "R8 no auto-off on adapter", rail_en, 1);

    // button off, with a press during drain
    expect_ev(EV_RST_DN, 0, 3, "R4 reset assert");
    expect_ev(EV_RAIL_DN, (S-1)*T, S*T+6, "R5 rail drop");
    press();
    wait_cyc(2);
    press();
    wait_cyc(S*T + 20);
    check(rail_en == 1'b0, "R11 press during drain ignored", rail_en, 0);

    // battery, longer delay, press during ramp, idle off
    adapter_present = 1'b0;
    reg_write(1'b1, 16'd10);
    reg_read(1'b1, rd);
    check(rd == 16'd10, "R13 delay readback", rd, 10);
    expect_ev(EV_RAIL_UP, 0, 3, "R2 rail rise");
    expect_ev(EV_RST_UP, 9*T, 10*T+6, "R3 reset release");
    press();
    wait_cyc(8);
    press();
    while (!periph_rst_n) wait_cyc(1);
    check(rail_en == 1'b1, "R11 press during ramp ignored", rail_en, 1);
    expect_ev(EV_RST_DN, (I-1)*T, I*T+6, "R6 idle reset assert");
    expect_ev(EV_RAIL_DN, (I-1)*T+(S-1)*T, I*T+S*T+10, "R6 idle rail drop");
    wait_cyc(I*T + S*T + 20);
    check(rail_en == 1'b0, "R6 off after idle", rail_en, 0);

    // key strobes keep it on
    power_on(10);
    for (int k = 0; k < 3; k++) begin
      wait_cyc(I*T - 40);
      key_strobe = 1'b1;
      wait_cyc(1);
      key_strobe = 1'b0;
    end
    check(rail_en == 1'b1 && periph_rst_n == 1'b1, "R7 keys hold power", periph_rst_n, 1);
    expect_ev(EV_RST_DN, (I-1)*T, I*T+6, "R7 idle after last key");
    expect_ev(EV_RAIL_DN, (I-1)*T+(S-1)*T, I*T+S*T+10, "R7 rail drop");
    wait_cyc(I*T + S*T + 20);

    // disable bit, then software off
    reg_write(1'b0, 16'h0001);
    reg_read(1'b0, rd);
    check(rd[0] == 1'b1, "R13 disable readback", rd[0], 1);
    power_on(10);
    wait_cyc(2*I*T);
    check(rail_en == 1'b1, "R9 no auto-off when disabled", rail_en, 1);
    expect_ev(EV_RST_DN, 0, 4, "R10 soft off reset");
    expect_ev(EV_RAIL_DN, (S-1)*T, S*T+8, "R10 soft off rail");
    reg_write(1'b0, 16'h0003);
    wait_cyc(S*T + 20);
    check(rail_en == 1'b0, "R10 off after soft request", rail_en, 0);

    // adapter blip restarts the count
    reg_write(1'b0, 16'h0000);
    power_on(10);
    wait_cyc(I*T - 20);
    adapter_present = 1'b1;
    wait_cyc(2);
    adapter_present = 1'b0;
    expect_ev(EV_RST_DN, (I-1)*T, I*T+6, "R8 count restart after adapter");
    expect_ev(EV_RAIL_DN, (I-1)*T+(S-1)*T, I*T+S*T+10, "R8 rail drop");
    wait_cyc(I*T - 10);
    check(periph_rst_n == 1'b1, "R8 still on after adapter blip", periph_rst_n, 1);
    wait_cyc(S*T + 40);

    check(q.size() == 0, "R5 all expected edges seen", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule